// File: doc/BRIEF.md
# Serial EEPROM Image Scanner

This block drives a three-wire serial EEPROM of the 93C46 family (a chip select, a serial clock, a data line into the device and a data line out of it) and reads 16-bit words from it. Every transaction raises chip select, sends a start bit and the read opcode, shifts a word address and then collects sixteen data bits. At the end it returns all device pins low. The serial clock runs in half-periods of `HALF_DIV` system clocks. This keeps the device within its rate limit.

When reset is released the engine works out the address width on its own. It first runs a throwaway read of address 0, sending up to `MAX_ABITS` address bits. It stops as soon as the device answers with the zero it drives once the address is complete. It then reads every word from 0 to 2^width − 1 in order, presents each one on the data port with a one-cycle strobe, and keeps a wrapping 16-bit sum. Once the scan ends it reports the width, the word count and whether the sum equals `CHECKSUM`.

After the scan the block waits for host requests. A strobe with a word address starts a single read, and the word comes back with the same done strobe. The engine accepts requests only while it is idle.

Top module: `mw_rom_scanner`

## Requirements
- R1: A transaction raises `ee_cs`, waits one half-period, then sends the bits 1, 1, 0 in that order. Each bit is placed on `ee_di` while `ee_sk` is low. `ee_sk` then goes high and low again. Every low phase and every high phase of `ee_sk` lasts exactly `HALF_DIV` clocks, and `ee_di` does not change while `ee_sk` is high.
- R2: The address follows the opcode, most significant bit first. Then 16 data bits are clocked in, most significant bit first. Each data bit is sampled from `ee_do` in the last clock of its `ee_sk` high phase.
- R3: `ee_sk` and `ee_di` are high only while `ee_cs` is high. All three are low between transactions and after the last one.
- R4: The first transaction after reset reads address 0 for sizing. `ee_do` is sampled at the end of each address bit's high phase. The first 0 ends the address, and the number of address bits sent becomes `abits`. If no 0 is seen, `abits` is `MAX_ABITS`. The data word of this read does not produce a `data_valid`.
- R5: After the sizing read the engine reads addresses 0 to 2^abits − 1 in ascending order, one transaction each. Each word appears on `data_out`, with its address on `data_addr`, during a one-cycle `data_valid` that comes after `ee_cs` has fallen.
- R6: When the scan ends, `scan_done` rises and `word_count` equals 2^abits. `sum_ok` is 1 exactly when the 16-bit wrapping sum of all scanned words equals `CHECKSUM` (0xBABA by default).
- R7: `rd_req` is accepted only when `busy` is low, which means the scan is done and no transaction is running. Otherwise it has no effect. An accepted request reads the word at the low `abits` bits of `rd_addr` and ends with one `data_valid`.
- R8: While reset is asserted, `ee_cs`, `ee_sk`, `ee_di`, `data_valid`, `scan_done` and `sum_ok` are all 0.
- R9: `data_valid` never stays high for two cycles in a row, and once `scan_done` is set it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |
| rd_req | input | 1 | Host read strobe |
| rd_addr | input | MAX_ABITS | Host word address |
| busy | output | 1 | Scan running or transaction in flight |
| data_valid | output | 1 | One-cycle strobe with each delivered word |
| data_out | output | 16 | Word read from the device |
| data_addr | output | MAX_ABITS | Address of the delivered word |
| scan_done | output | 1 | Start-up scan complete |
| abits | output | $clog2(MAX_ABITS+1) | Discovered address width |
| word_count | output | MAX_ABITS+1 | Number of words in the device |
| sum_ok | output | 1 | Image sum matched the checksum |

## Verification
The bench builds the engine with `HALF_DIV` = 2 and `MAX_ABITS` = 8. With a two-clock half-period each transaction takes a little over a hundred cycles. That makes full scans affordable for device widths of 4, 6 and 8 bits, and the 8-bit case covers the largest image the sizing read can find. A bench device model with a runtime-selectable width produces the sizing zero at the right bit. It also checks the opcode and the width of every clock phase, so both images with a correct sum and images with a wrong sum are reached. Host reads with high address bits set, and a request issued during the scan, test the masking rule and the rule that requests are ignored while the engine is busy.

// File: rtl/mw_rom_scanner.sv
`timescale 1ns/1ps
module mw_rom_scanner #(
  parameter int          HALF_DIV  = 50,
  parameter int          MAX_ABITS = 8,
  parameter logic [15:0] CHECKSUM  = 16'hBABA
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic                           ee_cs,
  output logic                           ee_sk,
  output logic                           ee_di,
  input  logic                           ee_do,
  input  logic                           rd_req,
  input  logic [MAX_ABITS-1:0]           rd_addr,
  output logic                           busy,
  output logic                           data_valid,
  output logic [15:0]                    data_out,
  output logic [MAX_ABITS-1:0]           data_addr,
  output logic                           scan_done,
  output logic [$clog2(MAX_ABITS+1)-1:0] abits,
  output logic [MAX_ABITS:0]             word_count,
  output logic                           sum_ok
);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int AW   = $clog2(MAX_ABITS + 1);
  localparam int CW   = $clog2(MAX_ABITS > 16 ? MAX_ABITS : 16);
  localparam logic [2:0] OPC = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_CSUP, S_OP, S_ADR, S_DAT, S_END} st_t;

  st_t                  st;
  logic                 hi, sizing;
  logic [CW-1:0]        cnt;
  logic [DIVW-1:0]      div;
  logic [MAX_ABITS-1:0] adr, last_adr;
  logic [15:0]          shreg, sum;
  logic                 tick;

  assign tick       = (div == '0);
  assign last_adr   = MAX_ABITS'((32'd1 << abits) - 32'd1);
  assign word_count = (MAX_ABITS+1)'(1) << abits;
  assign busy       = (st != S_IDLE) || !scan_done;
  assign ee_cs      = (st == S_CSUP) || (st == S_OP) || (st == S_ADR) || (st == S_DAT);
  assign ee_sk      = hi;

  always_comb begin
    case (st)
      S_OP:    ee_di = OPC[cnt[1:0]];
      S_ADR:   ee_di = adr[cnt];
      default: ee_di = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div <= DIVW'(HALF_DIV - 1);
    else if (st == S_IDLE || tick) div <= DIVW'(HALF_DIV - 1);
    else                       div <= div - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hi <= 1'b0; sizing <= 1'b1; cnt <= '0; adr <= '0;
      abits <= '0; shreg <= '0; sum <= '0; scan_done <= 1'b0; sum_ok <= 1'b0;
      data_valid <= 1'b0; data_out <= '0; data_addr <= '0;
    end else begin
      data_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (!scan_done) st <= S_CSUP;
          else if (rd_req) begin
            adr <= rd_addr & last_adr;
            st  <= S_CSUP;
          end
        S_CSUP:
          if (tick) begin st <= S_OP; cnt <= CW'(2); end
        S_OP:
          if (tick) begin
            hi <= !hi;
            if (hi) begin
              if (cnt == '0) begin
                st  <= S_ADR;
                cnt <= CW'((sizing ? MAX_ABITS : int'(abits)) - 1);
              end else cnt <= cnt - 1'b1;
            end
          end
        S_ADR:
          if (tick) begin
            hi <= !hi;
            if (hi) begin
              if (sizing && !ee_do) begin
                abits <= AW'(MAX_ABITS - int'(cnt));
                st <= S_DAT; cnt <= CW'(15);
              end else if (cnt == '0) begin
                if (sizing) abits <= AW'(MAX_ABITS);
                st <= S_DAT; cnt <= CW'(15);
              end else cnt <= cnt - 1'b1;
            end
          end
        S_DAT:
          if (tick) begin
            hi <= !hi;
            if (hi) begin
              shreg <= {shreg[14:0], ee_do};
              if (cnt == '0) st <= S_END;
              else cnt <= cnt - 1'b1;
            end
          end
        S_END:
          if (tick) begin
            st <= S_IDLE;
            if (sizing) begin
              sizing <= 1'b0;
              adr    <= '0;
              sum    <= '0;
            end else begin
              data_valid <= 1'b1;
              data_out   <= shreg;
              data_addr  <= adr;
              if (!scan_done) begin
                sum <= sum + shreg;
                if (adr == last_adr) begin
                  scan_done <= 1'b1;
                  sum_ok    <= (sum + shreg) == CHECKSUM;
                end else adr <= adr + 1'b1;
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mw_rom_scanner_chk #(
  parameter int MAX_ABITS = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ee_cs,
  input logic                           ee_sk,
  input logic                           ee_di,
  input logic                           data_valid,
  input logic                           scan_done,
  input logic [$clog2(MAX_ABITS+1)-1:0] abits
);
  assert_di_stable_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  assert_sk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  assert_idle_pins_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> (!ee_sk && !ee_di));
  assert_width_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (abits >= 1 && int'(abits) <= MAX_ABITS));
  assert_valid_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !ee_cs);
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done);
endmodule

bind mw_rom_scanner mw_rom_scanner_chk #(.MAX_ABITS(MAX_ABITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .data_valid(data_valid), .scan_done(scan_done), .abits(abits)
);

// File: tb/mw_rom_scanner_tb_top.sv
`timescale 1ns/1ps
module mw_rom_scanner_tb_top;
  localparam int HD = 2;
  localparam int MA = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di, ee_do = 1'b1;
  logic rd_req = 1'b0;
  logic [MA-1:0] rd_addr = '0;
  logic busy, data_valid, scan_done, sum_ok;
  logic [15:0] data_out;
  logic [MA-1:0] data_addr;
  logic [3:0] abits;
  logic [MA:0] word_count;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [256];
  int dev_w = 6;
  logic host_mode = 1'b0;

  always #5 clk = ~clk;

  mw_rom_scanner #(.HALF_DIV(HD), .MAX_ABITS(MA)) dut_i (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .data_valid(data_valid), .data_out(data_out), .data_addr(data_addr),
    .scan_done(scan_done), .abits(abits), .word_count(word_count), .sum_ok(sum_ok));

  // device model
  int bitn = 0, txn = 0, bad_op = 0, first_a = -1;
  logic cs_q = 1'b0;
  logic [2:0] op_rx;
  logic [7:0] a_rx;
  logic [15:0] outsh;
  always @(posedge ee_sk or ee_cs) begin
    if (ee_cs !== cs_q) begin
      cs_q = ee_cs;
      if (ee_cs) begin bitn = 0; op_rx = '0; a_rx = '0; ee_do = 1'b1; end
      else begin
        txn++;
        if (op_rx != 3'b110) bad_op++;
        if (first_a < 0) first_a = int'(a_rx);
        ee_do = 1'b1;
      end
    end else if (ee_sk) begin
      if (bitn < 3) op_rx = {op_rx[1:0], ee_di};
      else if (bitn < 3 + dev_w) begin
        a_rx = {a_rx[6:0], ee_di};
        if (bitn == 2 + dev_w) begin ee_do = 1'b0; outsh = mem[a_rx]; end
      end else begin
        ee_do = outsh[15]; outsh = {outsh[14:0], 1'b0};
      end
      bitn++;
    end
  end

  // phase width monitor
  int run_hi = 0, run_lo = 0, bad_run = 0;
  always @(posedge clk) begin
    if (ee_sk) begin
      run_hi++;
      if (run_lo != 0 && run_lo != HD) bad_run++;
      run_lo = 0;
    end else begin
      if (run_hi != 0 && run_hi != HD) bad_run++;
      run_hi = 0;
      if (ee_cs && bitn > 0) run_lo++;
    end
  end

  // output monitor
  int n_valid = 0, bad_data = 0, bad_order = 0, scan_idx = 0;
  always @(negedge clk) begin
    if (!rst_n) scan_idx = 0;
    else if (data_valid) begin
      n_valid++;
      if (data_out !== mem[data_addr]) bad_data++;
      if (!host_mode) begin
        if (int'(data_addr) != scan_idx) bad_order++;
        scan_idx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int w, input bit good);
    logic [15:0] s = '0;
    int n = 1 << w;
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h1357) ^ 16'h2468 ^ (w << 12));
    for (int i = 0; i < n - 1; i++) s += mem[i];
    mem[n-1] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
  endtask

  // one full start-up scan of a device of width w
  task automatic t_scan(input int w, input bit good, input bit poke);
    int t0, v0, op0, d0, o0, r0, guard;
    fill(w, good);
    dev_w = w;
    host_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R8", "pins in reset", {ee_cs, ee_sk, ee_di}, 0);
    chk(!data_valid && !scan_done && !sum_ok, "R8", "flags in reset",
        {data_valid, scan_done, sum_ok}, 0);
    t0 = txn; v0 = n_valid; op0 = bad_op; d0 = bad_data; o0 = bad_order; r0 = bad_run;
    first_a = -1;
    rst_n = 1'b1;
    if (poke) begin
      repeat (400) @(negedge clk);
      rd_addr = 8'd3; rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
    end
    guard = 0;
    while (!scan_done && guard < 60000) begin @(negedge clk); guard++; end
    repeat (2 * HD + 4) @(negedge clk);
    chk(scan_done, "R6", "scan finished", scan_done, 1);
    chk(int'(abits) == w, "R4", "discovered width", abits, w);
    chk(first_a == 0, "R4", "sizing address", first_a, 0);
    chk(txn - t0 == (1 << w) + 1, "R4", "transactions incl. sizing", txn - t0, (1 << w) + 1);
    chk(n_valid - v0 == (1 << w), "R5", "words delivered", n_valid - v0, 1 << w);
    chk(bad_order == o0, "R5", "ascending order errors", bad_order - o0, 0);
    chk(bad_data == d0, "R2", "data word mismatches", bad_data - d0, 0);
    chk(bad_op == op0, "R1", "opcode errors", bad_op - op0, 0);
    chk(bad_run == r0, "R1", "sk phase width errors", bad_run - r0, 0);
    chk(int'(word_count) == (1 << w), "R6", "word count", word_count, 1 << w);
    chk(sum_ok == good, "R6", "checksum flag", sum_ok, good);
    chk(!ee_cs && !ee_sk && !ee_di, "R3", "pins low after scan", {ee_cs, ee_sk, ee_di}, 0);
    chk(!busy, "R7", "idle after scan", busy, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(n_valid - v0 == (1 << w), "R7", "request during scan ignored", n_valid - v0, 1 << w);
    end
  endtask

  task automatic t_host(input logic [7:0] a);
    int v0 = n_valid, d0 = bad_data, guard = 0;
    logic [7:0] exp_a = a & 8'((1 << dev_w) - 1);
    host_mode = 1'b1;
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    chk(busy, "R7", "request accepted", busy, 1);
    while (!data_valid && guard < 2000) begin @(negedge clk); guard++; end
    chk(data_valid, "R7", "host read done strobe", data_valid, 1);
    chk(data_addr == exp_a, "R7", "masked host address", data_addr, exp_a);
    chk(data_out == mem[exp_a], "R2", "host read data", data_out, mem[exp_a]);
    @(negedge clk);
    chk(!data_valid, "R9", "single-cycle strobe", data_valid, 0);
    repeat (4) @(negedge clk);
    chk(n_valid - v0 == 1 && bad_data == d0, "R7", "one word per request", n_valid - v0, 1);
    chk(scan_done, "R9", "scan_done held", scan_done, 1);
  endtask

  initial begin
    t_scan(6, 1'b1, 1'b0);
    t_host(8'h05);
    t_host(8'hF5);
    t_scan(4, 1'b0, 1'b1);
    t_host(8'h0E);
    t_scan(8, 1'b1, 1'b0);
    t_host(8'hC3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule